// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. Two operands arrive with a 5-bit condition mask and a width select. The block compares the operands as signed numbers, as unsigned numbers and for equality. Each mask bit enables one of five outcomes. If any enabled outcome holds, the block raises a trap request and a program-exception cause code that marks a trap.

In narrow mode only the low half of each operand takes part. That is 32 bits at the default 64-bit width, and the upper halves are ignored. In wide mode the full operands are compared. The comparison logic is combinational. Its result is captured in a register stage, so the answer appears exactly one cycle after an input strobe.

Control is a two-state machine.
- `ST_IDLE`: no result is presented.
- `ST_EMIT`: the captured result is on the outputs for one cycle.
- Transition `take_strobe` (any state to `ST_EMIT`): taken when `in_valid` is high.
- Transition `drop_result` (any state to `ST_IDLE`): taken when `in_valid` is low.

Top module: `trap_cond_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when A is less than B as two's-complement signed numbers.
- R2: Mask bit 3 (value 0x08) enables a trap when A is greater than B as signed numbers.
- R3: Mask bit 2 (value 0x04) enables a trap when A equals B.
- R4: Mask bit 1 (value 0x02) enables a trap when A is less than B as unsigned numbers.
- R5: Mask bit 0 (value 0x01) enables a trap when A is greater than B as unsigned numbers.
- R6: `trap_req` is the OR of all enabled conditions. When `out_valid` is high, `cause_code` is 4'h2 (trap-type program exception) if `trap_req` is 1, and 4'h0 otherwise.
- R7: With `wide_sel` = 0, only bits [31:0] of each operand are compared, and the upper bits have no effect on the result.
- R8: With `wide_sel` = 1, all 64 bits of each operand are compared.
- R9: A mask of 5'b00000 never traps. A mask of 5'b11111 always traps.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. While `out_valid` is low, `trap_req` is 0 and `cause_code` is 4'h0.
- R11: After reset, `out_valid` and `trap_req` are 0 and `cause_code` is 4'h0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; operands and mask are sampled when high |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| cond_mask | input | 5 | Condition enable mask (bit 4 signed <, bit 3 signed >, bit 2 equal, bit 1 unsigned <, bit 0 unsigned >) |
| wide_sel | input | 1 | 1 = full-width compare, 0 = low-half compare |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| trap_req | output | 1 | Trap fires |
| cause_code | output | 4 | 4'h2 on trap, 4'h0 otherwise |

## Verification
The hardest case to reach from the ports is an operand pair whose upper halves order the operands one way while the lower halves order them the other way. A pair whose signed and unsigned orderings disagree is equally hard to reach. Random operands almost never produce either case.

The stimulus therefore builds operand pairs half by half, on purpose:
- pairs equal in the low half but different above it;
- pairs with the sign bit set at bit 31 or bit 63 on only one side.

These pairs are mixed with a few pseudo-random pairs. Each pair is swept through all 32 masks under both width settings, so every single condition is isolated and every combination of conditions is covered.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

    // Number of condition bits in the mask; fixed by the flag set below.
    localparam int COND_W  = 5;
    localparam int CAUSE_W = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_NONE = 4'h0;
    localparam logic [CAUSE_W-1:0] CAUSE_TRAP = 4'h2;

    // Member order matches mask bit order: first member is bit 4.
    typedef struct packed {
        logic lt_s;   // bit 4
        logic gt_s;   // bit 3
        logic eq;     // bit 2
        logic lt_u;   // bit 1
        logic gt_u;   // bit 0
    } cmp_flags_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } trap_state_e;

endpackage

// File: rtl/trap_lane_cmp.sv
// One comparison lane of width LANE_W: signed, unsigned and equality flags.
module trap_lane_cmp
    import trap_cmp_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] lhs,
    input  logic [LANE_W-1:0] rhs,
    output cmp_flags_t        flags
);

    logic signed [LANE_W-1:0] lhs_s;
    logic signed [LANE_W-1:0] rhs_s;

    always_comb begin
        lhs_s      = $signed(lhs);
        rhs_s      = $signed(rhs);
        flags.lt_s = lhs_s < rhs_s;
        flags.gt_s = lhs_s > rhs_s;
        flags.eq   = lhs == rhs;
        flags.lt_u = lhs < rhs;
        flags.gt_u = lhs > rhs;
    end

endmodule

// File: rtl/trap_width_sel.sv
// Runs a half-width and a full-width lane in parallel and picks one.
module trap_width_sel
    import trap_cmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              wide_sel,
    output cmp_flags_t        flags
);

    localparam int HALF_W  = DATA_W / 2;
    localparam int N_LANES = 2;

    cmp_flags_t lane_flags [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = HALF_W << g;
        trap_lane_cmp #(.LANE_W(LW)) u_lane (
            .lhs   (op_a[LW-1:0]),
            .rhs   (op_b[LW-1:0]),
            .flags (lane_flags[g])
        );
    end

    always_comb begin
        flags = wide_sel ? lane_flags[1] : lane_flags[0];
    end

endmodule

// File: rtl/trap_cond_eval.sv
// Masks the comparison flags and reduces them to one trap decision.
module trap_cond_eval
    import trap_cmp_pkg::*;
(
    input  cmp_flags_t        flags,
    input  logic [COND_W-1:0] cond_mask,
    output logic              fire
);

    logic [COND_W-1:0] hits;

    always_comb begin
        hits = flags & cond_mask;
        fire = |hits;
    end

endmodule

// File: rtl/trap_cond_unit.sv
module trap_cond_unit
    import trap_cmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  op_a,
    input  logic [DATA_W-1:0]  op_b,
    input  logic [COND_W-1:0]  cond_mask,
    input  logic               wide_sel,
    output logic               out_valid,
    output logic               trap_req,
    output logic [CAUSE_W-1:0] cause_code
);

    cmp_flags_t  sel_flags;
    logic        fire;
    trap_state_e state_q;
    trap_state_e state_d;
    logic        trap_q;
    logic [CAUSE_W-1:0] cause_q;

    trap_width_sel #(.DATA_W(DATA_W)) u_width (
        .op_a     (op_a),
        .op_b     (op_b),
        .wide_sel (wide_sel),
        .flags    (sel_flags)
    );

    trap_cond_eval u_eval (
        .flags     (sel_flags),
        .cond_mask (cond_mask),
        .fire      (fire)
    );

    // Next state: take_strobe / drop_result
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trap_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else if (in_valid) begin
            trap_q  <= fire;
            cause_q <= fire ? CAUSE_TRAP : CAUSE_NONE;
        end else begin
            trap_q  <= 1'b0;
            cause_q <= CAUSE_NONE;
        end
    end

    assign out_valid  = (state_q == ST_EMIT);
    assign trap_req   = trap_q;
    assign cause_code = cause_q;

endmodule

// File: rtl/trap_cond_chk.sv
module trap_cond_chk
    import trap_cmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [DATA_W-1:0]  op_a,
    input logic [DATA_W-1:0]  op_b,
    input logic [COND_W-1:0]  cond_mask,
    input logic               out_valid,
    input logic               trap_req,
    input logic [CAUSE_W-1:0] cause_code
);

    // R10
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!trap_req && cause_code == CAUSE_NONE));

    // R6
    cause_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cause_code == (trap_req ? CAUSE_TRAP : CAUSE_NONE)));

    // R9
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == '0) |=> !trap_req);

    // R9
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == '1) |=> trap_req);

    // R3
    equal_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask[2] && op_a == op_b) |=> trap_req);

endmodule

bind trap_cond_unit trap_cond_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .cond_mask  (cond_mask),
    .out_valid  (out_valid),
    .trap_req   (trap_req),
    .cause_code (cause_code)
);

// File: tb/tb_trap_cond_unit.sv
module tb_trap_cond_unit;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 64;
    localparam int N_PAIRS    = 16;
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] op_a = '0;
    logic [DW-1:0] op_b = '0;
    logic [4:0]    cond_mask = '0;
    logic          wide_sel = 1'b0;
    logic          out_valid;
    logic          trap_req;
    logic [3:0]    cause_code;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_cond_unit #(.DATA_W(DW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_a       (op_a),
        .op_b       (op_b),
        .cond_mask  (cond_mask),
        .wide_sel   (wide_sel),
        .out_valid  (out_valid),
        .trap_req   (trap_req),
        .cause_code (cause_code)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected trap decision from the requirements (R1..R5, R7, R8)
    function automatic logic exp_trap(input logic [63:0] a, input logic [63:0] b,
                                      input logic [4:0] m, input logic w);
        logic [63:0] ea, eb;
        logic lts, gts, eq, ltu, gtu;
        if (w) begin
            ea = a; eb = b;
            lts = $signed(ea) < $signed(eb);
            gts = $signed(ea) > $signed(eb);
        end else begin
            ea = {32'h0, a[31:0]}; eb = {32'h0, b[31:0]};
            lts = $signed(a[31:0]) < $signed(b[31:0]);
            gts = $signed(a[31:0]) > $signed(b[31:0]);
        end
        eq  = ea == eb;
        ltu = ea < eb;
        gtu = ea > eb;
        return (m[4] & lts) | (m[3] & gts) | (m[2] & eq) | (m[1] & ltu) | (m[0] & gtu);
    endfunction

    function automatic string tag_for(input logic [4:0] m, input logic w);
        if (m == 5'h00 || m == 5'h1f) return "R9";
        case (m)
            5'h10: return "R1";
            5'h08: return "R2";
            5'h04: return "R3";
            5'h02: return "R4";
            5'h01: return "R5";
            default: return w ? "R8" : "R7";
        endcase
    endfunction

    function automatic void make_pair(input int idx, output logic [63:0] a, output logic [63:0] b);
        logic [63:0] s;
        case (idx)
            0: begin a = 64'h0;                   b = 64'h0;                   end
            1: begin a = 64'd5;                   b = 64'd3;                   end
            2: begin a = 64'd3;                   b = 64'd5;                   end
            3: begin a = '1;                      b = 64'd1;                   end
            4: begin a = 64'd1;                   b = '1;                      end
            5: begin a = 64'h00000001_00000007;   b = 64'h00000002_00000007;   end
            6: begin a = 64'hFFFFFFFF_00000001;   b = 64'h00000000_80000000;   end
            7: begin a = 64'h00000000_7FFFFFFF;   b = 64'h00000000_80000000;   end
            default: begin
                s = 64'h9E3779B97F4A7C15 * (idx + 1);
                s = s ^ (s >> 29);
                a = s;
                b = (idx[0]) ? {~s[63:32], s[31:0]} : (s ^ {s[31:0], s[63:32]});
            end
        endcase
    endfunction

    task automatic run_vec(input logic [63:0] a, input logic [63:0] b,
                           input logic [4:0] m, input logic w);
        logic e;
        string t;
        @(negedge clk);
        op_a = a; op_b = b; cond_mask = m; wide_sel = w; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        e = exp_trap(a, b, m, w);
        t = tag_for(m, w);
        check(t, {63'h0, trap_req}, {63'h0, e});
        // R6 cause code and R10 valid timing
        check("R6", {59'h0, out_valid, cause_code}, {59'h0, 1'b1, (e ? 4'h2 : 4'h0)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", {62'h0, out_valid, trap_req}, 64'h0);
        check("R11", {60'h0, cause_code}, 64'h0);
        rst_n = 1'b1;

        // R10: a trapping setup without strobe must stay invisible
        @(negedge clk);
        op_a = 64'd1; op_b = 64'd1; cond_mask = 5'h1f; wide_sel = 1'b1; in_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R10", {61'h0, out_valid, trap_req, |cause_code}, 64'h0);
        end

        // R7: upper halves differ, low halves equal -> equality trap in narrow mode only
        run_vec(64'hAAAA0000_12345678, 64'h5555FFFF_12345678, 5'h04, 1'b0);
        run_vec(64'hAAAA0000_12345678, 64'h5555FFFF_12345678, 5'h04, 1'b1);

        for (int p = 0; p < N_PAIRS; p++) begin
            logic [63:0] a, b;
            make_pair(p, a, b);
            for (int w = 0; w < 2; w++) begin
                for (int m = 0; m < 32; m++) begin
                    run_vec(a, b, m[4:0], w[0]);
                end
            end
        end

        // R10: back-to-back strobes keep out_valid high and present each result
        @(negedge clk);
        op_a = 64'd2; op_b = 64'd9; cond_mask = 5'h02; wide_sel = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R10", {62'h0, out_valid, trap_req}, 64'h3);
        op_a = 64'd9; op_b = 64'd2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10", {62'h0, out_valid, trap_req}, 64'h2);
        @(negedge clk);
        check("R10", {62'h0, out_valid, trap_req}, 64'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule